// File: doc/BRIEF.md
# Read-Modify-Write Bus Cycle Controller

This block is the bus master used by a CPU sequencer to run memory cycles on an asynchronous, fully interlocked 16-bit bus. It runs three kinds of cycle: a plain read, a write (word or byte), and a read-pause. A read-pause is a read that tells the slave a write to the same location comes next. Memories whose reads destroy the stored data can then skip their restore step and keep the location locked.

The address is held in a dedicated bus address register. This register drives the address lines at all times and is kept apart from any general register file. When the sequencer later writes back the operand it fetched with a read-pause, it sets the reuse flag. The write then goes out to the held address and the address is not computed again. Write data comes only through the request port, which is fed from the datapath.

Each cycle follows the same handshake. The block drives address and control, waits one clock for them to settle, then raises the master strobe (MSYN). It waits for the slave strobe (SSYN), captures read data, drops MSYN, and finishes when SSYN falls. A cycle the slave never answers ends with a timeout error.

Top module: `busCycleCtrl`

## Requirements
- R1: After reset, reqReady is 1, busMsyn is 0, done, errTimeout and errProtocol are 0, busDataOe is 0 and busCtl is 00.
- R2: While a cycle is in progress, busCtl carries the kind of that cycle: read = 00, read-pause = 01, write word = 10, write byte = 11. busDataOe is 1 only for kinds 10 and 11, and busDataOut then carries the request's write data.
- R3: A request is accepted at a clock edge where reqValid is 1 and reqReady is 1. busMsyn goes high only after the second clock edge following acceptance, so address and control are stable for one full clock before MSYN.
- R4: For kinds 00 and 01, busDataIn is sampled at the edge where busSsyn is first seen high. The sampled value appears on rdData and is held until the next read.
- R5: A write with reqReuse = 1, issued while a read-pause is pending, goes to the address of that read-pause and ignores reqAddr. reqReuse has no effect on reads.
- R6: Any other accepted request loads reqAddr into the bus address register, and busAddr shows the new value.
- R7: A write with reqReuse = 1 while no read-pause is pending produces a one-clock pulse of done and errProtocol with no MSYN. A completed read-pause sets the pending state; any completed write clears it.
- R8: If busSsyn is not seen within TIMEOUT_CYCLES clocks of MSYN, MSYN is held high for exactly TIMEOUT_CYCLES clocks and then dropped. done and errTimeout then pulse for one clock and the block returns to idle.
- R9: done pulses for exactly one clock when a cycle ends, after busSsyn has fallen. reqReady is 1 only when idle, and a reqValid during a cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Sequencer requests a cycle |
| reqKind | input | 2 | Cycle kind (00 read, 01 read-pause, 10 write word, 11 write byte) |
| reqAddr | input | ADDR_W | Address for the cycle |
| reqWdata | input | DATA_W | Write data from the datapath |
| reqReuse | input | 1 | Write to the held address of the pending read-pause |
| reqReady | output | 1 | Block is idle and can accept a request |
| done | output | 1 | One-clock end-of-cycle pulse |
| rdData | output | DATA_W | Last captured read data |
| errTimeout | output | 1 | Cycle ended by missing slave response |
| errProtocol | output | 1 | Reuse write rejected, nothing pending |
| busAddr | output | ADDR_W | Bus address register contents |
| busCtl | output | 2 | Bus control code |
| busDataOut | output | DATA_W | Data driven to the bus |
| busDataOe | output | 1 | Enable for busDataOut |
| busDataIn | input | DATA_W | Data from the bus |
| busMsyn | output | 1 | Master sync strobe |
| busSsyn | input | 1 | Slave sync strobe |

## Verification
The bench keeps the default widths: an 18-bit address, so busAddr shows that the upper address bits are held, and 16-bit data. It builds the block with TIMEOUT_CYCLES = 12, which makes the exact length of the unanswered MSYN window short enough to count clock by clock. The bench's slave model can be given a chosen response delay or muted. This covers an immediate SSYN, a late SSYN and a slave that never answers, as well as a request raised in the middle of a handshake.

// File: rtl/bus_cycle_pkg.sv
package bus_cycle_pkg;
  typedef enum logic [1:0] {
    KIND_READ   = 2'b00,
    KIND_RPAUSE = 2'b01,
    KIND_WRWORD = 2'b10,
    KIND_WRBYTE = 2'b11
  } cycleKind_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WAIT_ACK,
    ST_WAIT_REL
  } ctlState_t;

  typedef struct packed {
    logic loadBar;
    logic loadWdata;
    logic captureRd;
  } dpStrobes_t;
endpackage

// File: rtl/busCycleDatapath.sv
module busCycleDatapath #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  bus_cycle_pkg::dpStrobes_t        strobes,
  input  logic [ADDR_W-1:0]                reqAddr,
  input  logic [DATA_W-1:0]                reqWdata,
  input  logic [DATA_W-1:0]                busDataIn,
  output logic [ADDR_W-1:0]                barOut,
  output logic [DATA_W-1:0]                wdataOut,
  output logic [DATA_W-1:0]                rdDataOut
);
  logic [ADDR_W-1:0] busAddrReg;
  logic [DATA_W-1:0] wdataReg;
  logic [DATA_W-1:0] rdReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busAddrReg <= '0;
      wdataReg   <= '0;
      rdReg      <= '0;
    end else begin
      if (strobes.loadBar)   busAddrReg <= reqAddr;
      if (strobes.loadWdata) wdataReg   <= reqWdata;
      if (strobes.captureRd) rdReg      <= busDataIn;
    end
  end

  assign barOut    = busAddrReg;
  assign wdataOut  = wdataReg;
  assign rdDataOut = rdReg;

  // R5: address register only moves when the control asks for a load
  a_r5_bar_held: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.loadBar) |-> $stable(busAddrReg));
  // R4: read data register only moves on a capture strobe
  a_r4_rd_held: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.captureRd) |-> $stable(rdReg));
endmodule

// File: rtl/busCycleControl.sv
module busCycleControl #(
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  logic [1:0]                  reqKind,
  input  logic                        reqReuse,
  input  logic                        busSsyn,
  output bus_cycle_pkg::dpStrobes_t   strobes,
  output logic                        reqReady,
  output logic                        done,
  output logic                        errTimeout,
  output logic                        errProtocol,
  output logic [1:0]                  busCtl,
  output logic                        busDataOe,
  output logic                        busMsyn
);
  import bus_cycle_pkg::*;

  localparam int CNT_W = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  ctlState_t        state;
  cycleKind_t       kind;
  logic [CNT_W-1:0] waitCnt;
  logic             pending;
  logic             reqIsWrite;
  logic             reqBadReuse;
  logic             accept;

  assign reqIsWrite  = reqKind[1];
  assign reqBadReuse = reqIsWrite && reqReuse && !pending;
  assign accept      = (state == ST_IDLE) && reqValid && !reqBadReuse;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      kind        <= KIND_READ;
      waitCnt     <= '0;
      pending     <= 1'b0;
      done        <= 1'b0;
      errTimeout  <= 1'b0;
      errProtocol <= 1'b0;
    end else begin
      done        <= 1'b0;
      errTimeout  <= 1'b0;
      errProtocol <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (reqValid && reqBadReuse) begin
            done        <= 1'b1;
            errProtocol <= 1'b1;
          end else if (accept) begin
            kind  <= cycleKind_t'(reqKind);
            state <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          waitCnt <= '0;
          state   <= ST_WAIT_ACK;
        end
        ST_WAIT_ACK: begin
          if (busSsyn) begin
            state <= ST_WAIT_REL;
          end else if (waitCnt == CNT_LAST) begin
            state      <= ST_IDLE;
            done       <= 1'b1;
            errTimeout <= 1'b1;
            pending    <= 1'b0;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        ST_WAIT_REL: begin
          if (!busSsyn) begin
            state <= ST_IDLE;
            done  <= 1'b1;
            if (kind == KIND_RPAUSE) pending <= 1'b1;
            else if (kind[1])        pending <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes           = '0;
    strobes.loadBar   = accept && !(reqIsWrite && reqReuse);
    strobes.loadWdata = accept && reqIsWrite;
    strobes.captureRd = (state == ST_WAIT_ACK) && busSsyn && !kind[1];
  end

  assign reqReady  = (state == ST_IDLE);
  assign busMsyn   = (state == ST_WAIT_ACK);
  assign busCtl    = (state == ST_IDLE) ? 2'b00 : kind;
  assign busDataOe = (state != ST_IDLE) && kind[1];

  // R9: no strobe while idle
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !busMsyn);
  // R7: protocol error pulse is a completion with no bus strobe
  a_r7_proto_done: assert property (@(posedge clk) disable iff (!rstN)
    errProtocol |-> done && !busMsyn);
  // R8: timeout ends the cycle
  a_r8_timeout_done: assert property (@(posedge clk) disable iff (!rstN)
    errTimeout |-> done && reqReady);
  // R8: strobe drops only after a slave response or a timeout
  a_r8_msyn_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busMsyn) |-> $past(busSsyn) || errTimeout);
endmodule

// File: rtl/busCycleCtrl.sv
module busCycleCtrl #(
  parameter int ADDR_W         = 18,
  parameter int DATA_W         = 16,
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqReuse,
  output logic              reqReady,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic              errTimeout,
  output logic              errProtocol,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busCtl,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  input  logic [DATA_W-1:0] busDataIn,
  output logic              busMsyn,
  input  logic              busSsyn
);
  bus_cycle_pkg::dpStrobes_t strobes;

  busCycleControl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqReuse(reqReuse), .busSsyn(busSsyn), .strobes(strobes),
    .reqReady(reqReady), .done(done), .errTimeout(errTimeout),
    .errProtocol(errProtocol), .busCtl(busCtl), .busDataOe(busDataOe),
    .busMsyn(busMsyn)
  );

  busCycleDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .busDataIn(busDataIn), .barOut(busAddr),
    .wdataOut(busDataOut), .rdDataOut(rdData)
  );

  // R3: address and control settled before the strobe rises
  a_r3_setup_stable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busMsyn) |-> $stable(busAddr) && $stable(busCtl));
  // R3: address and control held during the strobe
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (busMsyn && $past(busMsyn)) |-> $stable(busAddr) && $stable(busCtl));
  // R2: data drivers only for write codes
  a_r2_oe_write_only: assert property (@(posedge clk) disable iff (!rstN)
    busDataOe |-> busCtl[1]);
endmodule

// File: tb/busCycleCtrl_test.sv
module busCycleCtrl_test;
  localparam int AW = 18;
  localparam int DW = 16;
  localparam int TO = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [1:0]    reqKind = 2'b00;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic          reqReuse = 1'b0;
  logic          reqReady, done, errTimeout, errProtocol, busDataOe, busMsyn;
  logic [DW-1:0] rdData, busDataOut;
  logic [AW-1:0] busAddr;
  logic [1:0]    busCtl;
  logic [DW-1:0] busDataIn = '0;
  logic          busSsyn = 1'b0;

  int checks = 0;
  int errors = 0;

  busCycleCtrl #(.ADDR_W(AW), .DATA_W(DW), .TIMEOUT_CYCLES(TO)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReuse(reqReuse),
    .reqReady(reqReady), .done(done), .rdData(rdData),
    .errTimeout(errTimeout), .errProtocol(errProtocol), .busAddr(busAddr),
    .busCtl(busCtl), .busDataOut(busDataOut), .busDataOe(busDataOe),
    .busDataIn(busDataIn), .busMsyn(busMsyn), .busSsyn(busSsyn)
  );

  always #4 clk = ~clk;

  // slave model
  int            slaveDelay = 1;
  bit            slaveMute = 0;
  int            slaveWait = 0;
  int            msynRises = 0;
  bit            msynPrev = 0;
  logic [AW-1:0] seenAddr;
  logic [1:0]    seenCtl;
  logic [DW-1:0] seenData;
  logic          seenOe;

  function automatic logic [DW-1:0] memVal(logic [AW-1:0] a);
    return a[DW-1:0] ^ 16'h5A3C;
  endfunction

  always @(negedge clk) begin
    if (busMsyn && !msynPrev) begin
      msynRises++;
      seenAddr  = busAddr;
      seenCtl   = busCtl;
      seenData  = busDataOut;
      seenOe    = busDataOe;
      slaveWait = 0;
    end
    if (busMsyn && !slaveMute) begin
      if (slaveWait >= slaveDelay) begin
        busSsyn   = 1'b1;
        busDataIn = memVal(busAddr);
      end else slaveWait++;
    end
    if (!busMsyn) busSsyn = 1'b0;
    msynPrev = busMsyn;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-cycle observations
  int firstMsyn, doneSamples, msynHigh, lenCycles;
  bit sawErrT, sawErrP;

  task automatic runCycle(input logic [1:0] kind, input logic [AW-1:0] addr,
                          input logic [DW-1:0] wd, input logic reuse,
                          input bit interrupt = 0);
    int k;
    firstMsyn = -1; doneSamples = 0; msynHigh = 0; sawErrT = 0; sawErrP = 0;
    @(negedge clk);
    reqValid = 1'b1; reqKind = kind; reqAddr = addr; reqWdata = wd; reqReuse = reuse;
    @(negedge clk);
    reqValid = 1'b0;
    k = 1;
    while (k < 500) begin
      if (busMsyn) begin
        msynHigh++;
        if (firstMsyn < 0) firstMsyn = k;
        if (interrupt) begin
          reqValid = 1'b1; reqKind = 2'b10; reqAddr = 18'h3FFFF;
          reqWdata = 16'hDEAD; reqReuse = 1'b0;
        end
      end else if (interrupt) reqValid = 1'b0;
      if (done) begin
        doneSamples++;
        sawErrT = errTimeout; sawErrP = errProtocol;
        break;
      end
      @(negedge clk);
      k++;
    end
    reqValid = 1'b0;
    lenCycles = k;
    if (k >= 500) check("watchdog cycle", 0, 1);
    @(negedge clk);
    if (done) doneSamples++;
  endtask

  task automatic testReset();
    check("R1 ready", reqReady, 1);
    check("R1 msyn", busMsyn, 0);
    check("R1 done/err", {done, errTimeout, errProtocol}, 0);
    check("R1 oe/ctl", {busDataOe, busCtl}, 0);
  endtask

  task automatic testRead();
    int r0 = msynRises;
    slaveDelay = 2;
    runCycle(2'b00, 18'h2_1234, 16'h0, 1'b0);
    check("R2 read code", seenCtl, 2'b00);
    check("R2 read no oe", seenOe, 0);
    check("R3 msyn timing", firstMsyn, 2);
    check("R4 read data", rdData, memVal(18'h2_1234));
    check("R6 address", busAddr, 18'h2_1234);
    check("R9 done one clock", doneSamples, 1);
    check("R9 one cycle", msynRises - r0, 1);
    // R5: reuse ignored for reads, new address still loaded
    slaveDelay = 0;
    runCycle(2'b00, 18'h0_0F0F, 16'h0, 1'b1);
    check("R5 read ignores reuse", seenAddr, 18'h0_0F0F);
    check("R4 read data 2", rdData, memVal(18'h0_0F0F));
  endtask

  task automatic testReadPauseWrite();
    slaveDelay = 1;
    runCycle(2'b01, 18'h1_ABCD, 16'h0, 1'b0);
    check("R2 pause code", seenCtl, 2'b01);
    check("R4 pause data", rdData, memVal(18'h1_ABCD));
    runCycle(2'b10, 18'h0_0001, 16'hBEEF, 1'b1);
    check("R5 reuse address", seenAddr, 18'h1_ABCD);
    check("R2 write code", seenCtl, 2'b10);
    check("R2 write data", seenData, 16'hBEEF);
    check("R2 write oe", seenOe, 1);
    check("R4 rd held over write", rdData, memVal(18'h1_ABCD));
    check("R7 no error on valid reuse", sawErrP, 0);
  endtask

  task automatic testByteWrite();
    slaveDelay = 3;
    runCycle(2'b11, 18'h3_0002, 16'h00A5, 1'b0);
    check("R2 byte code", seenCtl, 2'b11);
    check("R6 byte address", seenAddr, 18'h3_0002);
    check("R2 byte data", seenData, 16'h00A5);
  endtask

  task automatic testProtocol();
    int r0;
    logic [AW-1:0] a0;
    // pending was cleared by the previous completed write
    r0 = msynRises; a0 = busAddr;
    runCycle(2'b10, 18'h0_7777, 16'h1111, 1'b1);
    check("R7 proto err", sawErrP, 1);
    check("R7 no msyn", msynRises - r0, 0);
    check("R7 addr unchanged", busAddr, a0);
    check("R7 one clock", lenCycles, 1);
    // pause then byte reuse is legal
    runCycle(2'b01, 18'h0_4444, 16'h0, 1'b0);
    runCycle(2'b11, 18'h0_0000, 16'h0033, 1'b1);
    check("R5 byte reuse", seenAddr, 18'h0_4444);
    check("R7 pending cleared", sawErrP, 0);
  endtask

  task automatic testTimeout();
    slaveMute = 1;
    runCycle(2'b00, 18'h0_0100, 16'h0, 1'b0);
    check("R8 timeout flag", sawErrT, 1);
    check("R8 msyn window", msynHigh, TO);
    check("R8 back idle", reqReady, 1);
    check("R8 msyn low", busMsyn, 0);
    slaveMute = 0;
  endtask

  task automatic testBusyIgnore();
    int r0 = msynRises;
    slaveDelay = 4;
    runCycle(2'b00, 18'h1_1111, 16'h0, 1'b0, 1);
    check("R9 busy req ignored addr", busAddr, 18'h1_1111);
    check("R9 busy one strobe", msynRises - r0, 1);
    check("R9 busy read data", rdData, memVal(18'h1_1111));
    check("R9 done single", doneSamples, 1);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRead();
    testReadPauseWrite();
    testByteWrite();
    testProtocol();
    testTimeout();
    testBusyIgnore();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule